// File: doc/BRIEF.md
# Programmable CPU Interrupt Controller

This block gathers up to 32 interrupt lines and presents them to a processor core. The core configures it through two registers. The enable register decides which lines may raise the core's request. The pending register records which lines are asking for service. A build-time parameter picks one of three pending behaviours:

- Transparent mode: the pending register is simply the live state of the inputs.
- Rising-edge mode: the pending register catches 0-to-1 transitions, and software clears bits by writing ones.
- Sticky-level mode: the pending register holds any high level until software clears it by writing zeros.

The block drives a single combined request to the core. It also offers a helper output with the number of the lowest pending line, so the service loop can walk the pending lines from the bottom up. Software changes single enable bits by reading the whole register, modifying it and writing it back. The inputs must already be synchronous to `clk`.

Register access is a plain single-cycle port with no handshake. A write takes effect at the clock edge where `reg_wr` is high. A read request on `reg_rd` returns the selected register on `reg_rdata` after that same edge, so the value is valid in the following cycle. `reg_rdata` holds its value between reads.

Top module: `cpu_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0, the pending register reads 0, `core_irq` is 0 and `pend_vld` is 0.
- R2: With `reg_sel`=0 a write loads the enable register from `reg_wdata`. A read returns the stored value one clock after the request. Bit i of both registers belongs to input line i.
- R3: `core_irq` is 1 exactly when some pending bit is 1 and its enable bit (1 = enabled) is also 1.
- R4: `pend_idx` is the index of the lowest-numbered pending bit, whether or not that line is enabled. `pend_vld` is 1 only when at least one pending bit is set.
- R5: In transparent mode (`MODE`=MODE_LEVEL) a read of the pending register (`reg_sel`=1) returns the live input levels, and writes to it change nothing.
- R6: In rising-edge mode (`MODE`=MODE_EDGE) a pending bit is set one clock after its input goes from 0 to 1. An input that stays high does not set the bit again after it has been cleared.
- R7: In rising-edge mode, writing 1 to a pending bit clears it. Bits written with 0 keep their value.
- R8: In rising-edge mode, when a new rising edge and a clear reach the same bit in the same cycle, the bit ends up set.
- R9: In sticky-level mode (`MODE`=MODE_LATCH) an input that is high at a clock edge sets its pending bit. The bit stays set after the input falls.
- R10: In sticky-level mode, a write to the pending register ANDs it with `reg_wdata`, so 0 clears a bit and 1 keeps it. An input that is still high sets its bit again in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_LINES | Interrupt lines, synchronous to clk |
| reg_sel | input | 1 | Register select: 0 enable, 1 pending |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read request |
| reg_wdata | input | N_LINES | Write data |
| reg_rdata | output | N_LINES | Read data, valid the cycle after a read request |
| core_irq | output | 1 | Combined interrupt request to the core |
| pend_idx | output | IDX_W | Index of the lowest pending line |
| pend_vld | output | 1 | At least one pending bit is set |

## Verification
The bench builds three copies of the controller with 32 lines, one for each `MODE` value (sticky-level, rising-edge and transparent), and drives all three from the same inputs and register port. A single write therefore means write-zero-to-clear for one copy, write-one-to-clear for another, and nothing for the third, so the contrast between the clear conventions appears in the same cycle. Line positions 0, 12 and 31 exercise both ends of the lowest-index search.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'd0,
    MODE_EDGE  = 2'd1,
    MODE_LATCH = 2'd2
  } pic_mode_e;

  localparam logic SEL_ENABLE  = 1'b0;
  localparam logic SEL_PENDING = 1'b1;
endpackage

// File: rtl/pic_enable_reg.sv
module pic_enable_reg #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [N_LINES-1:0] wdata,
  output logic [N_LINES-1:0] enable_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable_q <= '0;
    else if (wr_en) enable_q <= wdata;
  end

  assert_enable_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> enable_q == $past(wdata));
  assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(enable_q));
endmodule

// File: rtl/pic_pending_bank.sv
module pic_pending_bank
  import pic_pkg::*;
#(
  parameter int        N_LINES = 32,
  parameter pic_mode_e MODE    = MODE_LATCH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               wr_en,
  input  logic [N_LINES-1:0] wdata,
  output logic [N_LINES-1:0] pending
);
  generate
    if (MODE == MODE_LEVEL) begin : g_level
      assign pending = irq_in;
    end else if (MODE == MODE_EDGE) begin : g_edge
      logic [N_LINES-1:0] prev_q, pend_q, rise, clr;
      assign rise    = irq_in & ~prev_q;
      assign clr     = wr_en ? wdata : '0;
      assign pending = pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= '0;
          pend_q <= '0;
        end else begin
          prev_q <= irq_in;
          pend_q <= (pend_q & ~clr) | rise;
        end
      end

      // a new edge always leaves its bit set, even under a clear
      assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> (pend_q & $past(rise)) == $past(rise));
      // ones written without a new edge come out cleared
      assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pend_q & $past(wdata) & ~$past(rise)) == '0);
    end else begin : g_latch
      logic [N_LINES-1:0] pend_q;
      assign pending = pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend_q <= '0;
        else if (wr_en) pend_q <= (pend_q & wdata) | irq_in;
        else            pend_q <= pend_q | irq_in;
      end

      assert_latch_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_in) |=> (pend_q & $past(irq_in)) == $past(irq_in));
      assert_w0c_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pend_q & ~$past(wdata) & ~$past(irq_in)) == '0);
    end
  endgenerate
endmodule

// File: rtl/pic_lowest_finder.sv
module pic_lowest_finder #(
  parameter int N_LINES = 32,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pending,
  output logic [IDX_W-1:0]   idx,
  output logic               vld
);
  always_comb begin
    idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pending[i]) idx = IDX_W'(i);
    end
  end
  assign vld = |pending;

  assert_idx_points_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> pending[idx]);
  assert_idx_is_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (pending & ((N_LINES'(1) << idx) - N_LINES'(1))) == '0);
endmodule

// File: rtl/cpu_irq_ctrl.sv
module cpu_irq_ctrl
  import pic_pkg::*;
#(
  parameter int        N_LINES = 32,
  parameter pic_mode_e MODE    = MODE_LATCH,
  parameter int        IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               core_irq,
  output logic [IDX_W-1:0]   pend_idx,
  output logic               pend_vld
);
  logic [N_LINES-1:0] enable_q, pending;
  logic               wr_enable, wr_pending;

  assign wr_enable  = reg_wr && (reg_sel == SEL_ENABLE);
  assign wr_pending = reg_wr && (reg_sel == SEL_PENDING);

  pic_enable_reg #(.N_LINES(N_LINES)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_enable), .wdata(reg_wdata),
    .enable_q(enable_q)
  );

  pic_pending_bank #(.N_LINES(N_LINES), .MODE(MODE)) u_pending (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_pending),
    .wdata(reg_wdata), .pending(pending)
  );

  pic_lowest_finder #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_find (
    .clk(clk), .rst_n(rst_n), .pending(pending), .idx(pend_idx), .vld(pend_vld)
  );

  assign core_irq = |(pending & enable_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= (reg_sel == SEL_ENABLE) ? enable_q : pending;
  end

  assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> (|enable_q));
  assert_irq_needs_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> pend_vld);
endmodule

// File: tb/sim_cpu_irq_ctrl.sv
`timescale 1ns/1ps
module sim_cpu_irq_ctrl;
  import pic_pkg::*;
  localparam int N = 32;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_in = '0, wdata = '0;
  logic sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [N-1:0] rdata_l, rdata_e, rdata_v;
  logic irq_l, irq_e, irq_v, vld_l, vld_e, vld_v;
  logic [IW-1:0] idx_l, idx_e, idx_v;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  cpu_irq_ctrl #(.N_LINES(N), .MODE(MODE_LATCH)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(sel), .reg_wr(wr),
    .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata_l), .core_irq(irq_l),
    .pend_idx(idx_l), .pend_vld(vld_l));
  cpu_irq_ctrl #(.N_LINES(N), .MODE(MODE_EDGE)) u1 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(sel), .reg_wr(wr),
    .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata_e), .core_irq(irq_e),
    .pend_idx(idx_e), .pend_vld(vld_e));
  cpu_irq_ctrl #(.N_LINES(N), .MODE(MODE_LEVEL)) u2 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(sel), .reg_wr(wr),
    .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata_v), .core_irq(irq_v),
    .pend_idx(idx_v), .pend_vld(vld_v));

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic s, logic [N-1:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_read(logic s);
    @(negedge clk); sel = s; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic set_irq(logic [N-1:0] v);
    @(negedge clk); irq_in = v;
  endtask

  task automatic pulse_irq(logic [N-1:0] v);
    set_irq(v); set_irq('0);
  endtask

  task automatic t_reset;
    do_read(SEL_ENABLE);
    check("R1 enable u0", rdata_l, '0); check("R1 enable u1", rdata_e, '0);
    do_read(SEL_PENDING);
    check("R1 pending u0", rdata_l, '0); check("R1 pending u1", rdata_e, '0);
    check("R1 core_irq", {irq_l, irq_e, irq_v}, '0);
    check("R1 pend_vld", {vld_l, vld_e, vld_v}, '0);
  endtask

  task automatic t_capture;
    pulse_irq(32'h20);
    do_read(SEL_PENDING);
    check("R9 latch holds after drop", rdata_l, 32'h20);
    check("R6 edge sets", rdata_e, 32'h20);
    check("R5 level live", rdata_v, 32'h0);
    check("R4 idx 5", {vld_l, 27'd0, idx_l}, {1'b1, 27'd0, 5'd5});
    check("R4 level no pending", vld_v, 1'b0);
    check("R3 masked off", {irq_l, irq_e}, 2'b00);
  endtask

  task automatic t_enable;
    do_write(SEL_ENABLE, 32'h20);
    do_read(SEL_ENABLE);
    check("R2 enable readback", rdata_e, 32'h20);
    check("R3 irq u0/u1/u2", {irq_l, irq_e, irq_v}, 3'b110);
  endtask

  task automatic t_clear_conventions;
    do_write(SEL_PENDING, ~32'h20);
    do_read(SEL_PENDING);
    check("R10 zero clears", rdata_l, 32'h0);
    check("R7 zero keeps", rdata_e, 32'h20);
    do_write(SEL_PENDING, 32'h20);
    do_read(SEL_PENDING);
    check("R7 one clears", rdata_e, 32'h0);
    check("R10 one keeps clear bit clear", rdata_l, 32'h0);
    check("R3 irq dropped", irq_e, 1'b0);
  endtask

  task automatic t_held_level;
    set_irq(32'h08);
    do_read(SEL_PENDING);
    check("R5 level live", rdata_v, 32'h08);
    do_write(SEL_PENDING, 32'h0);
    do_read(SEL_PENDING);
    check("R5 write ignored", rdata_v, 32'h08);
    check("R10 still-high re-sets", rdata_l, 32'h08);
    do_write(SEL_PENDING, '1);
    do_read(SEL_PENDING);
    check("R6 held high no re-set", rdata_e, 32'h0);
    check("R10 ones keep", rdata_l, 32'h08);
    do_write(SEL_ENABLE, 32'h08);
    check("R3 level irq", irq_v, 1'b1);
    set_irq('0);
    @(negedge clk);
    check("R5 level follows drop", {vld_v, irq_v}, 2'b00);
    check("R9 latch irq stays", irq_l, 1'b1);
    do_write(SEL_PENDING, 32'h0);
    check("R10 cleared after drop", vld_l, 1'b0);
  endtask

  task automatic t_race;
    pulse_irq(32'h80);
    @(negedge clk); irq_in = 32'h80; sel = SEL_PENDING; wdata = 32'h80; wr = 1'b1;
    @(negedge clk); irq_in = '0; wr = 1'b0;
    do_read(SEL_PENDING);
    check("R8 edge beats clear", rdata_e, 32'h80);
    do_write(SEL_PENDING, 32'h80);
    do_write(SEL_PENDING, 32'h0);
    do_read(SEL_PENDING);
    check("R7 cleanup", rdata_e, 32'h0);
  endtask

  task automatic t_lowest;
    pulse_irq(32'h8000_1000);
    check("R4 idx 12 edge", {27'd0, idx_e}, 32'd12);
    check("R4 idx 12 latch", {27'd0, idx_l}, 32'd12);
    do_write(SEL_PENDING, 32'h1000);
    check("R4 idx 31 edge", {vld_e, 26'd0, idx_e}, {1'b1, 26'd0, 5'd31});
    check("R4 idx 12 latch after and", {27'd0, idx_l}, 32'd12);
    pulse_irq(32'h1);
    check("R4 idx 0", {22'd0, idx_e, idx_l}, 32'd0);
    do_write(SEL_PENDING, 32'h0);
    do_write(SEL_PENDING, '1);
    check("R4 none pending", {vld_l, vld_e}, 2'b00);
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture();
    t_enable();
    t_clear_conventions();
    t_held_level();
    t_race();
    t_lowest();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule